// File: doc/BRIEF.md
# Synchronous Dual-Ratio Clock Divider

This block turns one input clock into two divided clocks whose shared rising edges fall on the same input edge. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter or one sixth of the input rate. Both outputs are decoded from a single twelve-phase state machine, which is the least common multiple of the three ratios. Because they share that state, a common edge can never drift, even if the block leaves power-up without a reset.

An active-low enable is sampled on the falling input edge. The dividers therefore start and stop only in the half-cycle where the internal clock is low. While the block is disabled, the phase is frozen and both outputs are held low. Counting resumes from the frozen phase. An asynchronous master reset returns the phase to its start point, clears the enable flop and drives both outputs low. Several instances can be brought into step by releasing that reset together. For synthesis, the gated internal clock is modelled as a run qualifier on flops that all use the input clock.

The phase machine has twelve states, `PH_00` to `PH_11`. Transition *advance* steps to the next state on each rising input edge while running, and goes from `PH_11` back to `PH_00`. Transition *hold* keeps the state while the block is disabled. Transition *clear* is the asynchronous move to `PH_00` on master reset. `PH_00` is the frame start: there, every output pattern is low, and any new ratio selection is taken up.

Top module: `dual_ratio_clk_div`

## Requirements
- R1: With `sel_a` = 0, `out_a` divides by 2. On the n-th counted edge after reset it is high exactly when (n-1) mod 2 is 0.
- R2: With `sel_a` = 1, `out_a` divides by 4. On counted edge n it is high exactly when (n-1) mod 4 < 2.
- R3: `out_b` divides by 4 when `sel_b` = 0 and by 6 when `sel_b` = 1, always at 50% duty. On counted edge n it is high exactly when (n-1) mod D < D/2. For divide-by-6 this gives three edges high, then three low.
- R4: Both outputs rise together on the first counted edge after reset. They rise together again on every counted edge n with (n-1) mod 12 = 0.
- R5: `en_n` is active low and is sampled only on the falling input edge. A change takes effect at the first rising edge after the falling edge that captured it. A pulse that begins after a falling edge and ends before the next falling edge is ignored.
- R6: While the block is disabled, both outputs are low on every rising edge and the phase does not move. After re-enable, the next counted edge continues the sequence from where it stopped.
- R7: While `mr` is high, both outputs are low at once, without waiting for a clock edge. The phase returns to its start and the enable flop clears. After release, the count restarts at n = 1.
- R8: A change on `sel_a` or `sel_b` is taken up only on the counted edge that leaves the frame start. That is the edge where (n-1) mod 12 = 0. Between those edges, the previous ratio stays in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| mr | input | 1 | Asynchronous master reset, active high |
| en_n | input | 1 | Enable, active low, sampled on the falling edge of `clk_in` |
| sel_a | input | 1 | Ratio select for output A: 0 = divide by 2, 1 = divide by 4 |
| sel_b | input | 1 | Ratio select for output B: 0 = divide by 4, 1 = divide by 6 |
| out_a | output | 1 | Divided clock A |
| out_b | output | 1 | Divided clock B |

## Verification
All four select combinations are run for two full twelve-edge frames from reset. The per-edge expected levels come from the modulo formula. This separates the divide-by-2 and divide-by-4 decodes on A from the divide-by-4 and divide-by-6 decodes on B, and shows whether the common rising edges coincide. A pause in the middle of a frame, followed by resumption, shows whether the phase is frozen or lost. An enable pulse that falls entirely between a falling and a rising edge shows whether the enable is sampled on the falling edge or is level-sensitive. A select change in the middle of a frame, and a reset asserted while an output is high, show whether ratio changes wait for the frame boundary and whether the reset acts without a clock.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int FRAME_LEN = 12;
    localparam int PHASE_W   = $clog2(FRAME_LEN);

    typedef enum logic [PHASE_W-1:0] {
        PH_00, PH_01, PH_02, PH_03, PH_04, PH_05,
        PH_06, PH_07, PH_08, PH_09, PH_10, PH_11
    } phase_t;

    // level of each candidate ratio in a given phase
    typedef struct packed {
        logic half;     // divide by 2
        logic quarter;  // divide by 4
        logic sixth;    // divide by 6
    } wave_t;

    function automatic wave_t phase_wave(input phase_t p);
        wave_t w;
        unique case (p)
            PH_00:   w = '{half: 1'b0, quarter: 1'b0, sixth: 1'b0};
            PH_01:   w = '{half: 1'b1, quarter: 1'b1, sixth: 1'b1};
            PH_02:   w = '{half: 1'b0, quarter: 1'b1, sixth: 1'b1};
            PH_03:   w = '{half: 1'b1, quarter: 1'b0, sixth: 1'b1};
            PH_04:   w = '{half: 1'b0, quarter: 1'b0, sixth: 1'b0};
            PH_05:   w = '{half: 1'b1, quarter: 1'b1, sixth: 1'b0};
            PH_06:   w = '{half: 1'b0, quarter: 1'b1, sixth: 1'b0};
            PH_07:   w = '{half: 1'b1, quarter: 1'b0, sixth: 1'b1};
            PH_08:   w = '{half: 1'b0, quarter: 1'b0, sixth: 1'b1};
            PH_09:   w = '{half: 1'b1, quarter: 1'b1, sixth: 1'b1};
            PH_10:   w = '{half: 1'b0, quarter: 1'b1, sixth: 1'b0};
            PH_11:   w = '{half: 1'b1, quarter: 1'b0, sixth: 1'b0};
            default: w = '{half: 1'b0, quarter: 1'b0, sixth: 1'b0};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cdiv_en_sync.sv
module cdiv_en_sync (
    input  logic clk_in,
    input  logic mr,
    input  logic en_n,
    output logic run
);

    // falling-edge capture: run only changes while clk_in is low
    always_ff @(negedge clk_in or posedge mr) begin
        if (mr) run <= 1'b0;
        else    run <= ~en_n;
    end

endmodule

// File: rtl/cdiv_phase_fsm.sv
module cdiv_phase_fsm
    import cdiv_pkg::*;
(
    input  logic   clk_in,
    input  logic   mr,
    input  logic   run,
    output phase_t phase,
    output phase_t phase_nxt,
    output logic   frame_start
);

    always_comb begin
        phase_nxt = phase;
        if (run) begin
            unique case (phase)
                PH_00:   phase_nxt = PH_01;
                PH_01:   phase_nxt = PH_02;
                PH_02:   phase_nxt = PH_03;
                PH_03:   phase_nxt = PH_04;
                PH_04:   phase_nxt = PH_05;
                PH_05:   phase_nxt = PH_06;
                PH_06:   phase_nxt = PH_07;
                PH_07:   phase_nxt = PH_08;
                PH_08:   phase_nxt = PH_09;
                PH_09:   phase_nxt = PH_10;
                PH_10:   phase_nxt = PH_11;
                PH_11:   phase_nxt = PH_00;
                default: phase_nxt = PH_00;
            endcase
        end
    end

    always_ff @(posedge clk_in or posedge mr) begin
        if (mr) phase <= PH_00;
        else    phase <= phase_nxt;
    end

    assign frame_start = (phase == PH_00);

    // R6: a stopped divider keeps its phase
    p_freeze_r6: assert property (@(posedge clk_in) disable iff (mr)
        !run |=> $stable(phase));

    // R4: the frame closes after twelve counted edges
    p_wrap_r4: assert property (@(posedge clk_in) disable iff (mr)
        (run && phase == PH_11) |=> (phase == PH_00));

endmodule

// File: rtl/cdiv_wave_gen.sv
module cdiv_wave_gen
    import cdiv_pkg::*;
(
    input  logic   clk_in,
    input  logic   mr,
    input  logic   run,
    input  logic   frame_start,
    input  phase_t phase_nxt,
    input  logic   sel_a,
    input  logic   sel_b,
    output logic   out_a,
    output logic   out_b
);

    logic  sel_a_q, sel_b_q;
    logic  sel_a_eff, sel_b_eff;
    wave_t lvl;

    always_comb begin
        sel_a_eff = frame_start ? sel_a : sel_a_q;
        sel_b_eff = frame_start ? sel_b : sel_b_q;
        lvl       = phase_wave(phase_nxt);
    end

    // ratio selections are latched only when leaving the frame start
    always_ff @(posedge clk_in or posedge mr) begin
        if (mr) begin
            sel_a_q <= 1'b0;
            sel_b_q <= 1'b0;
        end else if (run && frame_start) begin
            sel_a_q <= sel_a;
            sel_b_q <= sel_b;
        end
    end

    always_ff @(posedge clk_in or posedge mr) begin
        if (mr) begin
            out_a <= 1'b0;
            out_b <= 1'b0;
        end else if (run) begin
            out_a <= sel_a_eff ? lvl.quarter : lvl.half;
            out_b <= sel_b_eff ? lvl.sixth   : lvl.quarter;
        end else begin
            out_a <= 1'b0;
            out_b <= 1'b0;
        end
    end

    // R4: leaving the frame start raises both outputs together
    p_common_rise_r4: assert property (@(posedge clk_in) disable iff (mr)
        (run && frame_start) |=> (out_a && out_b));

    // R6: outputs rest low while the block is stopped
    p_idle_low_r6: assert property (@(posedge clk_in) disable iff (mr)
        !run |=> (!out_a && !out_b));

    // R8: latched ratios move only at the frame boundary
    p_sel_hold_r8: assert property (@(posedge clk_in) disable iff (mr)
        !(run && frame_start) |=> ($stable(sel_a_q) && $stable(sel_b_q)));

endmodule

// File: rtl/dual_ratio_clk_div.sv
module dual_ratio_clk_div
    import cdiv_pkg::*;
(
    input  logic clk_in,
    input  logic mr,
    input  logic en_n,
    input  logic sel_a,
    input  logic sel_b,
    output logic out_a,
    output logic out_b
);

    logic   run;
    logic   frame_start;
    phase_t phase;
    phase_t phase_nxt;

    cdiv_en_sync u_en_sync (
        .clk_in (clk_in),
        .mr     (mr),
        .en_n   (en_n),
        .run    (run)
    );

    cdiv_phase_fsm u_phase_fsm (
        .clk_in      (clk_in),
        .mr          (mr),
        .run         (run),
        .phase       (phase),
        .phase_nxt   (phase_nxt),
        .frame_start (frame_start)
    );

    cdiv_wave_gen u_wave_gen (
        .clk_in      (clk_in),
        .mr          (mr),
        .run         (run),
        .frame_start (frame_start),
        .phase_nxt   (phase_nxt),
        .sel_a       (sel_a),
        .sel_b       (sel_b),
        .out_a       (out_a),
        .out_b       (out_b)
    );

    // R5: a rising edge after a stopped falling edge leaves the phase alone
    p_run_gate_r5: assert property (@(posedge clk_in) disable iff (mr)
        (!run && phase == PH_00) |=> (phase == PH_00));

endmodule

// File: tb/test_dual_ratio_clk_div.sv
module test_dual_ratio_clk_div;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic mr, en_n, sel_a, sel_b;
    logic out_a, out_b;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   n_edge = 0;
    logic eff_a = 1'b0;
    logic eff_b = 1'b0;
    bit   done = 1'b0;

    // stimulus: {sel_a, sel_b}; expected divisors for A and B
    localparam logic [1:0] VEC_SEL [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    localparam int         VEC_DA  [4] = '{2, 2, 4, 4};
    localparam int         VEC_DB  [4] = '{4, 6, 4, 6};

    dual_ratio_clk_div i_dual_ratio_clk_div (
        .clk_in (clk),
        .mr     (mr),
        .en_n   (en_n),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .out_a  (out_a),
        .out_b  (out_b)
    );

    function automatic logic wave(input int n, input int d);
        return ((n - 1) % d) < (d / 2);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s edge %0d: actual %b expected %b", tag, what, n_edge, act, exp);
        end
    endtask

    // one counted edge, checked against the frame-latched ratio model
    task automatic edge_on(input string tag);
        @(posedge clk); #2;
        n_edge++;
        if ((n_edge - 1) % 12 == 0) begin
            eff_a = sel_a;
            eff_b = sel_b;
            chk(out_a & out_b, 1'b1, "R4", "common rise");
        end
        chk(out_a, wave(n_edge, eff_a ? 4 : 2), (tag != "") ? tag : (eff_a ? "R2" : "R1"), "out_a");
        chk(out_b, wave(n_edge, eff_b ? 6 : 4), (tag != "") ? tag : "R3", "out_b");
    endtask

    task automatic edge_off(input string tag);
        @(posedge clk); #2;
        chk(out_a, 1'b0, tag, "out_a idle");
        chk(out_b, 1'b0, tag, "out_b idle");
    endtask

    task automatic do_reset();
        mr = 1'b1;
        #1;
        chk(out_a, 1'b0, "R7", "out_a in reset");
        chk(out_b, 1'b0, "R7", "out_b in reset");
        @(posedge clk); #2;
        chk(out_a, 1'b0, "R7", "out_a held");
        mr = 1'b0;
        n_edge = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        mr = 1'b1; en_n = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
        #2;

        // vector table: every ratio pair over two frames
        for (int v = 0; v < 4; v++) begin
            {sel_a, sel_b} = VEC_SEL[v];
            do_reset();
            for (int k = 0; k < 24; k++) begin
                @(posedge clk); #2;
                n_edge++;
                chk(out_a, wave(n_edge, VEC_DA[v]), (VEC_DA[v] == 2) ? "R1" : "R2", "out_a table");
                chk(out_b, wave(n_edge, VEC_DB[v]), "R3", "out_b table");
                if ((n_edge - 1) % 12 == 0)
                    chk(out_a & out_b, 1'b1, "R4", "table common rise");
            end
        end

        // pause mid-frame and resume from the frozen phase
        sel_a = 1'b0; sel_b = 1'b1;
        do_reset();
        repeat (5) edge_on("");
        en_n = 1'b1;
        edge_off("R5");
        edge_off("R6");
        edge_off("R6");
        en_n = 1'b0;
        repeat (8) edge_on("R6");

        // enable pulse between a falling and a rising edge is ignored
        #4 en_n = 1'b1;
        #2 en_n = 1'b0;
        repeat (2) edge_on("R5");

        // ratio change in mid-frame waits for the frame boundary
        sel_a = 1'b0; sel_b = 1'b0;
        do_reset();
        repeat (4) edge_on("");
        sel_a = 1'b1; sel_b = 1'b1;
        repeat (20) edge_on("R8");

        // asynchronous reset while out_a is high
        sel_a = 1'b0; sel_b = 1'b0;
        do_reset();
        edge_on("");
        chk(out_a, 1'b1, "R7", "out_a high before reset");
        do_reset();
        repeat (3) edge_on("R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule